// File: doc/BRIEF.md
# Linearity Calibration Word Transfer Handshake

The block keeps a 160-bit linearity correction factor in an internal store and moves it, one word at a time, to and from a single 30-bit data register that software can read and write. Six ready bits, one per word, carry the handshake. The direction of a transfer is set by polarity. If software drives a ready bit from 1 to 0, the block reads that word out of the store into the data register. If software drives a ready bit from 0 to 1, the block writes the data register into that word of the store. In both cases the bit keeps showing its old value until the transfer is finished.

Each transfer takes a fixed number of cycles, set by a latency counter. A busy flag stays high for that time. A calibration-complete pulse loads a freshly computed factor into the store and sets all six ready bits. Toggles that break the rules are dropped and set a sticky error flag. The rules are: exactly one bit may change, no transfer may be in flight, and the converter must be enabled with no conversion running.

Top module: `lincal_xfer`

## Requirements
- R1: After reset the ready bits, the data register, the factor store, busy and the error flag all read 0.
- R2: A cycle with `cal_done` high loads `cal_factor` into the store, sets all six ready bits and cancels any transfer in flight. A control write in the same cycle is ignored and raises no error.
- R3: A control write that clears exactly one set bit starts a read. Busy rises on the next cycle and stays high for `LAT` cycles while the bit still reads 1. The bit then reads 0, and the data register holds word k, which is factor bits 30k+29 down to 30k (k = 0..4, bit k of the control word).
- R4: Reading word 5 (bit 5) returns factor bits 159:150 in data bits 9:0, and data bits 29:10 read 0.
- R5: A control write that sets exactly one clear bit starts a write. `LAT` cycles later, word k of the store equals the data register, the bit reads 1, and all other factor bits are unchanged. For word 5 only data bits 9:0 are stored.
- R6: A control write that changes two or more bits is ignored and sets the error flag.
- R7: A control write that changes any bit while busy is high is ignored and sets the error flag. The transfer in flight finishes normally.
- R8: A control write that changes a bit while `conv_en` is low, or while `reg_run` or `inj_run` is high, is ignored and sets the error flag.
- R9: A control write equal to the current ready bits has no effect and raises no error.
- R10: The error flag, once set, stays set until reset.
- R11: A data register write while busy is low is visible on `dat_rdata` on the next cycle. A data register write while busy is high is ignored.
- R12: The ready bits never change more than one bit per cycle, except on a calibration-complete pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_done | input | 1 | Calibration-complete pulse |
| cal_factor | input | 160 | Factor produced by calibration |
| conv_en | input | 1 | Converter enabled |
| reg_run | input | 1 | Regular conversion in progress |
| inj_run | input | 1 | Injected conversion in progress |
| ctl_wr | input | 1 | Write strobe for the ready bits |
| ctl_wdata | input | 6 | New value written to the ready bits |
| dat_wr | input | 1 | Write strobe for the data register |
| dat_wdata | input | 30 | Value written to the data register |
| rdy_bits | output | 6 | Ready bits, one per word |
| dat_rdata | output | 30 | Data register contents |
| factor | output | 160 | Correction factor store |
| busy | output | 1 | Transfer in flight |
| err | output | 1 | Sticky illegal-toggle flag |

## Verification
Reads are run on a low word, a middle word and the short last word. This separates an offset mistake from a padding mistake. Writes are run on the last word and on word 0, and then read back, which shows whether a write touches its neighbours. Each rejected pattern is tried on its own after a fresh reset, so each one is shown to set the error flag by itself: a two-bit change, a toggle while busy, a toggle while disabled, and a toggle while a regular or injected conversion runs. A calibration pulse is sent during a transfer and alongside a control write, to show that it wins in both cases.

// File: rtl/lincal_pkg.sv
package lincal_pkg;
  // Transfer direction equals the value the ready bit ends up holding
  typedef enum logic {
    XF_READ  = 1'b0,
    XF_WRITE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/lincal_guard.sv
module lincal_guard #(
  parameter int NW = 6,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          ctl_wr,
  input  logic [NW-1:0] ctl_wdata,
  input  logic [NW-1:0] rdy,
  input  logic          busy,
  input  logic          upd_ok,
  input  logic          cal_done,
  output logic          start,
  output logic [IW-1:0] start_idx,
  output logic          start_dir,
  output logic          illegal
);
  logic [NW-1:0] diff;
  int            nchg;

  function automatic logic [IW-1:0] low_index(input logic [NW-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = NW - 1; k >= 0; k--) begin
      if (v[k]) r = IW'(k);
    end
    return r;
  endfunction

  always_comb begin
    diff      = ctl_wdata ^ rdy;
    nchg      = $countones(diff);
    start_idx = low_index(diff);
    start_dir = ctl_wdata[start_idx];
    start     = ctl_wr && !cal_done && (nchg == 1) && !busy && upd_ok;
    illegal   = ctl_wr && !cal_done && (nchg != 0) && !start;
  end
endmodule

// File: rtl/lincal_timer.sv
module lincal_timer #(
  parameter int LAT = 4,
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);                                        // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy);                             // R3
endmodule

// File: rtl/lincal_store.sv
module lincal_store
  import lincal_pkg::*;
#(
  parameter int FACT_W = 160,
  parameter int WORD_W = 30,
  localparam int NW = (FACT_W + WORD_W - 1) / WORD_W,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1,
  localparam int LAST_W = FACT_W - (NW - 1) * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_done,
  input  logic [FACT_W-1:0] cal_factor,
  input  logic              dat_wr,
  input  logic [WORD_W-1:0] dat_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [IW-1:0]     idx,
  input  xfer_dir_e         dir,
  output logic [FACT_W-1:0] factor,
  output logic [WORD_W-1:0] dat
);
  // Word i sits at bit offset i*WORD_W; the last word is zero-padded on read
  function automatic logic [WORD_W-1:0] pick_word(input logic [FACT_W-1:0] f,
                                                  input logic [IW-1:0] i);
    logic [FACT_W+WORD_W-1:0] sh;
    sh = {{WORD_W{1'b0}}, f} >> (int'(i) * WORD_W);
    return sh[WORD_W-1:0];
  endfunction

  function automatic logic [FACT_W-1:0] put_word(input logic [FACT_W-1:0] f,
                                                 input logic [IW-1:0] i,
                                                 input logic [WORD_W-1:0] w);
    logic [FACT_W+WORD_W-1:0] ext, msk, ins;
    ext = {{WORD_W{1'b0}}, f};
    msk = {{FACT_W{1'b0}}, {WORD_W{1'b1}}} << (int'(i) * WORD_W);
    ins = {{FACT_W{1'b0}}, w} << (int'(i) * WORD_W);
    ext = (ext & ~msk) | ins;
    return ext[FACT_W-1:0];
  endfunction

  logic rd_done, wr_done;
  assign rd_done = done && (dir == XF_READ);
  assign wr_done = done && (dir == XF_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      factor <= '0;
    end else if (cal_done) begin
      factor <= cal_factor;
    end else if (wr_done) begin
      factor <= put_word(factor, idx, dat);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat <= '0;
    end else if (rd_done) begin
      dat <= pick_word(factor, idx);
    end else if (dat_wr && !busy) begin
      dat <= dat_wdata;
    end
  end

  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(dat));                      // R11

  generate
    if (LAST_W < WORD_W) begin : g_pad
      AST_LAST_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && (int'(idx) == NW - 1)) |=> (dat[WORD_W-1:LAST_W] == '0)); // R4
    end
  endgenerate
endmodule

// File: rtl/lincal_xfer.sv
module lincal_xfer
  import lincal_pkg::*;
#(
  parameter int FACT_W = 160,
  parameter int WORD_W = 30,
  parameter int LAT    = 4,
  localparam int NW = (FACT_W + WORD_W - 1) / WORD_W,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_done,
  input  logic [FACT_W-1:0] cal_factor,
  input  logic              conv_en,
  input  logic              reg_run,
  input  logic              inj_run,
  input  logic              ctl_wr,
  input  logic [NW-1:0]     ctl_wdata,
  input  logic              dat_wr,
  input  logic [WORD_W-1:0] dat_wdata,
  output logic [NW-1:0]     rdy_bits,
  output logic [WORD_W-1:0] dat_rdata,
  output logic [FACT_W-1:0] factor,
  output logic              busy,
  output logic              err
);
  logic          upd_ok;
  logic          start, illegal, xfer_done;
  logic [IW-1:0] start_idx, cur_idx;
  logic          start_dir;
  xfer_dir_e     cur_dir;
  logic [NW-1:0] rdy_q;
  logic          err_q;

  assign upd_ok   = conv_en && !reg_run && !inj_run;
  assign rdy_bits = rdy_q;
  assign err      = err_q;

  lincal_guard #(.NW(NW)) i_guard (
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .rdy       (rdy_q),
    .busy      (busy),
    .upd_ok    (upd_ok),
    .cal_done  (cal_done),
    .start     (start),
    .start_idx (start_idx),
    .start_dir (start_dir),
    .illegal   (illegal)
  );

  lincal_timer #(.LAT(LAT)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .abort (cal_done),
    .busy  (busy),
    .done  (xfer_done)
  );

  lincal_store #(.FACT_W(FACT_W), .WORD_W(WORD_W)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_done   (cal_done),
    .cal_factor (cal_factor),
    .dat_wr     (dat_wr),
    .dat_wdata  (dat_wdata),
    .busy       (busy),
    .done       (xfer_done),
    .idx        (cur_idx),
    .dir        (cur_dir),
    .factor     (factor),
    .dat        (dat_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      cur_dir <= XF_READ;
    end else if (start) begin
      cur_idx <= start_idx;
      cur_dir <= xfer_dir_e'(start_dir);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
    end else if (cal_done) begin
      rdy_q <= '1;
    end else if (xfer_done) begin
      rdy_q[cur_idx] <= cur_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (illegal) err_q <= 1'b1;
  end

  AST_ONE_BIT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_done |=> ($countones(rdy_q ^ $past(rdy_q)) <= 1));  // R12
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done && !cal_done) |=> $stable(rdy_q));   // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);                                         // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);                                        // R10
  AST_CAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (&rdy_q && !busy));                         // R2
endmodule

// File: tb/test_lincal_xfer.sv
module test_lincal_xfer;
  localparam int LAT = 4;
  localparam logic [159:0] P1 = {5{32'hA5C3_0F96}};
  localparam logic [159:0] P2 = {32'h1357_9BDF, 32'h2468_ACE0, 32'hDEAD_BEEF,
                                 32'h0F1E_2D3C, 32'h8899_AABB};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cal_done = 1'b0;
  logic [159:0] cal_factor = '0;
  logic         conv_en = 1'b0, reg_run = 1'b0, inj_run = 1'b0;
  logic         ctl_wr = 1'b0;
  logic [5:0]   ctl_wdata = '0;
  logic         dat_wr = 1'b0;
  logic [29:0]  dat_wdata = '0;
  logic [5:0]   rdy_bits;
  logic [29:0]  dat_rdata;
  logic [159:0] factor;
  logic         busy, err;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lincal_xfer #(.LAT(LAT)) i_lincal_xfer (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done), .cal_factor(cal_factor),
    .conv_en(conv_en), .reg_run(reg_run), .inj_run(inj_run),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .rdy_bits(rdy_bits), .dat_rdata(dat_rdata), .factor(factor),
    .busy(busy), .err(err)
  );

  // ---------------- behavioural reference model ----------------
  logic [5:0]   m_rdy;
  logic [159:0] m_fact;
  logic [29:0]  m_dat;
  bit           m_busy, m_err, m_dir;
  int           m_cnt, m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = '0; m_fact = '0; m_dat = '0;
      m_busy = 0; m_err = 0; m_dir = 0; m_cnt = 0; m_idx = 0;
    end else begin
      bit was_busy;
      logic [5:0] old_rdy;
      was_busy = m_busy;
      old_rdy  = m_rdy;
      if (cal_done) begin
        m_fact = cal_factor; m_rdy = 6'h3F; m_busy = 0;
      end else begin
        if (was_busy) begin
          if (m_cnt == 0) begin
            m_busy = 0;
            m_rdy[m_idx] = m_dir;
            for (int b = 0; b < 30; b++) begin
              int pos;
              pos = 30 * m_idx + b;
              if (m_dir) begin
                if (pos < 160) m_fact[pos] = m_dat[b];
              end else begin
                m_dat[b] = (pos < 160) ? m_fact[pos] : 1'b0;
              end
            end
          end else m_cnt--;
        end
        if (ctl_wr) begin
          int n, first;
          n = 0; first = -1;
          for (int k = 0; k < 6; k++)
            if (ctl_wdata[k] != old_rdy[k]) begin n++; if (first < 0) first = k; end
          if (n != 0) begin
            if (was_busy || n != 1 || !conv_en || reg_run || inj_run) m_err = 1;
            else begin
              m_busy = 1; m_cnt = LAT - 1; m_idx = first; m_dir = ctl_wdata[first];
            end
          end
        end
      end
      if (dat_wr && !was_busy) m_dat = dat_wdata;
    end
  end

  task automatic chk(string tag, string what, logic [159:0] act, logic [159:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "model rdy_bits", 160'(rdy_bits), 160'(m_rdy));
      chk("R3", "model dat_rdata", 160'(dat_rdata), 160'(m_dat));
      chk("R5", "model factor", factor, m_fact);
      chk("R7", "model busy", 160'(busy), 160'(m_busy));
      chk("R10", "model err", 160'(err), 160'(m_err));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; conv_en = 1'b0; reg_run = 1'b0; inj_run = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_cal(logic [159:0] f);
    cal_done = 1'b1; cal_factor = f;
    @(negedge clk);
    cal_done = 1'b0;
  endtask

  task automatic wr_ctl(logic [5:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic set_dat(logic [29:0] v);
    dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rdy", 160'(rdy_bits), 0);
    chk("R1", "dat", 160'(dat_rdata), 0);
    chk("R1", "factor", factor, 0);
    chk("R1", "busy/err", 160'({busy, err}), 0);

    conv_en = 1'b1;
    pulse_cal(P1);
    chk("R2", "rdy after cal", 160'(rdy_bits), 160'h3F);
    chk("R2", "factor after cal", factor, P1);

    // R3 read word 0
    wr_ctl(6'h3E);
    chk("R3", "busy after start", 160'(busy), 1);
    chk("R3", "old bit held", 160'(rdy_bits), 160'h3F);
    repeat (LAT - 1) @(negedge clk);
    chk("R3", "still busy", 160'(busy), 1);
    @(negedge clk);
    chk("R3", "rdy after read", 160'(rdy_bits), 160'h3E);
    chk("R3", "word0", 160'(dat_rdata), 160'(P1[29:0]));
    // R3 read word 3
    wr_ctl(6'h36);
    repeat (LAT) @(negedge clk);
    chk("R3", "word3", 160'(dat_rdata), 160'(P1[119:90]));
    // R4 read last word
    wr_ctl(6'h16);
    repeat (LAT) @(negedge clk);
    chk("R4", "word5 pad+slice", 160'(dat_rdata), 160'({20'h0, P1[159:150]}));

    // R11 data write accepted while idle
    set_dat(30'h2AAA_AAAA);
    chk("R11", "dat write idle", 160'(dat_rdata), 160'h2AAA_AAAA);
    // R5 write last word
    wr_ctl(6'h36);
    repeat (LAT) @(negedge clk);
    chk("R5", "rdy after write5", 160'(rdy_bits), 160'h36);
    chk("R5", "word5 stored", 160'(factor[159:150]), 160'h2AA);
    chk("R5", "rest untouched", 160'(factor[149:0]), 160'(P1[149:0]));
    // R5 write word 0 and read back
    set_dat(30'h0123_4567);
    wr_ctl(6'h37);
    repeat (LAT) @(negedge clk);
    chk("R5", "word0 stored", 160'(factor[29:0]), 160'h0123_4567);
    set_dat(30'h0);
    wr_ctl(6'h36);
    repeat (LAT) @(negedge clk);
    chk("R5", "word0 readback", 160'(dat_rdata), 160'h0123_4567);

    // R9 no-change write
    wr_ctl(6'h36);
    chk("R9", "no busy", 160'(busy), 0);
    chk("R9", "no err", 160'(err), 0);

    // R11 data write during busy ignored
    set_dat(30'h00F0_F0F0);
    wr_ctl(6'h37);
    set_dat(30'h3FFF_FFFF);
    chk("R11", "dat held while busy", 160'(dat_rdata), 160'h00F0_F0F0);
    repeat (LAT - 1) @(negedge clk);
    chk("R11", "stored old dat", 160'(factor[29:0]), 160'h00F0_F0F0);

    // R8 conversion running
    reg_run = 1'b1;
    wr_ctl(6'h36);
    chk("R8", "err reg_run", 160'(err), 1);
    chk("R8", "no busy", 160'(busy), 0);
    repeat (LAT) @(negedge clk);
    chk("R8", "rdy unchanged", 160'(rdy_bits), 160'h37);
    reg_run = 1'b0;
    // R10 sticky
    repeat (10) @(negedge clk);
    chk("R10", "err sticks", 160'(err), 1);

    // R6 multi-bit change
    do_reset(); conv_en = 1'b1; pulse_cal(P2);
    wr_ctl(6'h3C);
    chk("R6", "err two bits", 160'(err), 1);
    repeat (LAT) @(negedge clk);
    chk("R6", "rdy unchanged", 160'(rdy_bits), 160'h3F);

    // R7 toggle while busy
    do_reset(); conv_en = 1'b1; pulse_cal(P2);
    wr_ctl(6'h3E);
    wr_ctl(6'h3D);
    chk("R7", "err busy toggle", 160'(err), 1);
    repeat (LAT - 1) @(negedge clk);
    chk("R7", "first completes", 160'(rdy_bits), 160'h3E);
    chk("R7", "word0 of P2", 160'(dat_rdata), 160'(P2[29:0]));

    // R8 disabled, then injected running
    do_reset(); pulse_cal(P2);
    wr_ctl(6'h3E);
    chk("R8", "err disabled", 160'(err), 1);
    do_reset(); conv_en = 1'b1; inj_run = 1'b1; pulse_cal(P2);
    wr_ctl(6'h3E);
    chk("R8", "err inj_run", 160'(err), 1);
    inj_run = 1'b0;

    // R2 override of in-flight transfer, and same-cycle control write
    do_reset(); conv_en = 1'b1; pulse_cal(P1);
    wr_ctl(6'h3E);
    @(negedge clk);
    pulse_cal(P2);
    chk("R2", "busy cancelled", 160'(busy), 0);
    chk("R2", "factor P2", factor, P2);
    repeat (LAT) @(negedge clk);
    chk("R2", "no late completion", 160'(rdy_bits), 160'h3F);
    chk("R2", "dat untouched", 160'(dat_rdata), 0);
    ctl_wr = 1'b1; ctl_wdata = 6'h3E; cal_done = 1'b1; cal_factor = P1;
    @(negedge clk);
    ctl_wr = 1'b0; cal_done = 1'b0;
    chk("R2", "same-cycle write ignored", 160'({busy, err, rdy_bits}), 160'h3F);

    // R12 bits move one at a time: two reads in sequence
    wr_ctl(6'h1F);
    repeat (LAT) @(negedge clk);
    wr_ctl(6'h1E);
    repeat (LAT) @(negedge clk);
    chk("R12", "sequential reads", 160'(rdy_bits), 160'h1E);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule